// File: doc/BRIEF.md
# I/O Decode Range Matcher

This block decides whether an incoming 16-bit I/O port cycle falls inside one of four programmable windows. When it does, the cycle is to be forwarded to the low-pin-count bus. Each window is a 32-bit configuration word with three fields: an enable bit, a dword-aligned base, and a six-bit set of address bits that are ignored during the compare. The two lowest address bits are never compared, so every window covers at least four consecutive ports. For example, the word 0x911 opens ports 0x910 to 0x913.

The windows are written and read through a configuration port addressed by byte offset. An I/O lookup is presented with a valid strobe, and the result comes back on the next clock edge. The result is a hit flag and the number of the winning window. When several windows match, the lowest-numbered one wins. Generating the bus cycle itself is left to the logic that consumes the hit.

Top module: `io_range_decoder`

## Requirements
- R1: After reset, all four window words read 0, `hit` is 0 and `hit_idx` is 0.
- R2: Window n (n = 0..3) is at byte offset 0x84 + 4*n. A write to that offset stores bit 0 (enable), bits 15:2 (base) and bits 23:18 (ignore set). All other bits read back as 0, so writing 0xFFFFFFFF reads back 0x00FCFFFD.
- R3: A write to any other offset changes no window. A read from any other offset returns 0.
- R4: A window whose bit 0 is 0 never produces a hit.
- R5: An enabled window matches when the address, with bits 1:0 and the ignored bits cleared, equals the base (bits 15:2, low two bits zero). With 0x911, ports 0x910 to 0x913 hit, while 0x90F and 0x914 miss.
- R6: Word bit 18+k makes address bit 2+k ignored (k = 0..5). If a base bit lies in an ignored position and is 1, that window can never match.
- R7: When several enabled windows match, `hit_idx` reports the lowest-numbered one.
- R8: `hit` and `hit_idx` are registered and reflect the lookup presented in the cycle before. Without `io_valid`, `hit` is 0. Whenever `hit` is 0, `hit_idx` is 0.
- R9: A lookup in the same cycle as a configuration write is compared against the window contents before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Word at `cfg_addr`, combinational |
| io_valid | input | 1 | I/O lookup strobe |
| io_addr | input | 16 | I/O port address to match |
| hit | output | 1 | Registered: lookup fell in an enabled window |
| hit_idx | output | 2 | Registered: lowest matching window number |

## Verification
Read data is combinational, so the bench checks it shortly after it sets the offset, within the same cycle. A write takes effect at the clock edge on which `cfg_we` is high. A lookup result appears after exactly one edge. The bench drives inputs on the falling edge, lets one rising edge pass, and checks on the next falling edge. Back-to-back lookups are checked on successive falling edges. This shows that each result belongs to the previous cycle's address and not to an earlier one.

// File: rtl/iodec_pkg.sv
package iodec_pkg;
    parameter int unsigned NUM_RANGES = 4;
    parameter int unsigned ADDR_W     = 16;
    parameter int unsigned DATA_W     = 32;
    parameter int unsigned OFF_W      = 8;
    parameter int unsigned FIRST_OFF  = 'h84;
    parameter int unsigned OFF_STEP   = 4;
    parameter int unsigned EN_BIT     = 0;
    parameter int unsigned BASE_LSB   = 2;
    parameter int unsigned BASE_MSB   = 15;
    parameter int unsigned MASK_LSB   = 18;
    parameter int unsigned MASK_W     = 6;

    localparam int unsigned BASE_W = BASE_MSB - BASE_LSB + 1;
    localparam int unsigned IDX_W  = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1;

    typedef struct packed {
        logic [MASK_W-1:0] ign;
        logic [BASE_W-1:0] base;
        logic              en;
    } window_t;

    function automatic window_t word_to_window(input logic [DATA_W-1:0] w);
        window_t r;
        r.en   = w[EN_BIT];
        r.base = w[BASE_MSB:BASE_LSB];
        r.ign  = w[MASK_LSB +: MASK_W];
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] window_to_word(input window_t r);
        logic [DATA_W-1:0] w;
        w = '0;
        w[EN_BIT] = r.en;
        w[BASE_MSB:BASE_LSB] = r.base;
        w[MASK_LSB +: MASK_W] = r.ign;
        return w;
    endfunction

    function automatic logic [ADDR_W-1:0] ignore_bits(input window_t r);
        logic [ADDR_W-1:0] m;
        m = '0;
        m[BASE_LSB-1:0] = '1;
        m[BASE_LSB +: MASK_W] = r.ign;
        return m;
    endfunction

    function automatic logic [ADDR_W-1:0] base_addr(input window_t r);
        logic [ADDR_W-1:0] a;
        a = '0;
        a[BASE_MSB:BASE_LSB] = r.base;
        return a;
    endfunction
endpackage

// File: rtl/iodec_regs.sv
module iodec_regs
    import iodec_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [OFF_W-1:0]                  cfg_addr,
    input  logic [DATA_W-1:0]                 cfg_wdata,
    output logic [DATA_W-1:0]                 cfg_rdata,
    output window_t [NUM_RANGES-1:0]          windows
);
    logic             sel_hit;
    logic [IDX_W-1:0] sel_idx;

    always_comb begin
        sel_hit = 1'b0;
        sel_idx = '0;
        for (int i = 0; i < NUM_RANGES; i++) begin
            if (cfg_addr == OFF_W'(FIRST_OFF + OFF_STEP * i)) begin
                sel_hit = 1'b1;
                sel_idx = IDX_W'(i);
            end
        end
    end

    window_t [NUM_RANGES-1:0] win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (cfg_we && sel_hit)
            win_d[sel_idx] = word_to_window(cfg_wdata);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign windows   = win_q;
    assign cfg_rdata = sel_hit ? window_to_word(win_q[sel_idx]) : '0;

    // R3: a write aimed at no window leaves every window unchanged
    p_stray_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !sel_hit) |=> $stable(win_q));

    // R2: a decoded write lands in the addressed window
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && sel_hit) |=> windows[$past(sel_idx)] == word_to_window($past(cfg_wdata)));
endmodule

// File: rtl/iodec_match.sv
module iodec_match
    import iodec_pkg::*;
(
    input  window_t [NUM_RANGES-1:0] windows,
    input  logic [ADDR_W-1:0]        io_addr,
    output logic [NUM_RANGES-1:0]    match_vec
);
    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_cmp
        logic [ADDR_W-1:0] kept;
        assign kept         = io_addr & ~ignore_bits(windows[g]);
        assign match_vec[g] = windows[g].en && (kept == base_addr(windows[g]));
    end
endmodule

// File: rtl/iodec_pick.sv
module iodec_pick
    import iodec_pkg::*;
(
    input  logic [NUM_RANGES-1:0] match_vec,
    output logic                  any,
    output logic [IDX_W-1:0]      idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NUM_RANGES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/io_range_decoder.sv
module io_range_decoder
    import iodec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              io_valid,
    input  logic [15:0]       io_addr,
    output logic              hit,
    output logic [1:0]        hit_idx
);
    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } result_t;

    window_t [NUM_RANGES-1:0] windows;
    logic [NUM_RANGES-1:0]    match_vec;
    logic [NUM_RANGES-1:0]    en_vec;
    logic                     any_match;
    logic [IDX_W-1:0]         pick_idx;
    result_t                  res_d, res_q;

    iodec_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .windows   (windows)
    );

    iodec_match u_match (
        .windows   (windows),
        .io_addr   (io_addr),
        .match_vec (match_vec)
    );

    iodec_pick u_pick (
        .match_vec (match_vec),
        .any       (any_match),
        .idx       (pick_idx)
    );

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_en
        assign en_vec[g] = windows[g].en;
    end

    always_comb begin
        res_d.hit = io_valid && any_match;
        res_d.idx = res_d.hit ? pick_idx : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign hit     = res_q.hit;
    assign hit_idx = res_q.idx;

    // R8: no strobe, no hit on the following cycle
    p_idle_no_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !io_valid |=> !hit);

    // R8: index is zero whenever there is no hit
    p_idx_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> hit_idx == '0);

    // R4: the reported window was enabled when the lookup was taken
    p_enabled_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> |($past(en_vec) & (NUM_RANGES'(1) << hit_idx)));

    // R7: no lower-numbered window matched the lookup
    p_lowest_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ($past(match_vec) & ((NUM_RANGES'(1) << hit_idx) - NUM_RANGES'(1))) == '0);

    // R5: a strobed lookup that matched any window is reported
    p_match_reported_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(io_valid) && (|$past(match_vec))) |-> hit);
endmodule

// File: tb/tb_io_range_decoder.sv
module tb_io_range_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        io_valid = 1'b0;
    logic [15:0] io_addr = '0;
    logic        hit;
    logic [1:0]  hit_idx;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    io_range_decoder dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_valid(io_valid),
        .io_addr(io_addr), .hit(hit), .hit_idx(hit_idx)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_check(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(req, cfg_rdata, exp);
    endtask

    task automatic lookup(input logic [15:0] a, input logic eh, input logic [1:0] ei,
                          input string req);
        @(negedge clk);
        io_addr = a; io_valid = 1'b1;
        @(negedge clk);
        io_valid = 1'b0;
        check({req, " hit"}, {31'b0, hit}, {31'b0, eh});
        check({req, " idx"}, {30'b0, hit_idx}, {30'b0, ei});
    endtask

    task automatic clear_all();
        for (int i = 0; i < 4; i++) cfg_write(8'(8'h84 + 4 * i), 32'h0);
    endtask

    task automatic t_reset();
        check("R1 hit", {31'b0, hit}, 32'h0);
        check("R1 idx", {30'b0, hit_idx}, 32'h0);
        for (int i = 0; i < 4; i++) cfg_check(8'(8'h84 + 4 * i), 32'h0, "R1 word");
    endtask

    task automatic t_stray();
        cfg_write(8'h86, 32'h911);
        cfg_write(8'h94, 32'h911);
        cfg_write(8'h80, 32'h911);
        for (int i = 0; i < 4; i++) cfg_check(8'(8'h84 + 4 * i), 32'h0, "R3 unchanged");
        cfg_check(8'h94, 32'h0, "R3 read other");
        lookup(16'h0910, 1'b0, 2'd0, "R3 no window");
    endtask

    task automatic t_regs();
        cfg_write(8'h88, 32'hFFFF_FFFF);
        cfg_check(8'h88, 32'h00FC_FFFD, "R2 kept bits");
        cfg_write(8'h90, 32'h1234_5679);
        cfg_check(8'h90, 32'h0034_5679, "R2 fields");
        cfg_check(8'h84, 32'h0, "R2 neighbour");
        cfg_write(8'h8C, 32'h0000_0A41);
        cfg_check(8'h8C, 32'h0000_0A41, "R2 plain");
        clear_all();
    endtask

    task automatic t_basic();
        cfg_write(8'h84, 32'h911);
        for (int a = 'h910; a <= 'h913; a++) lookup(16'(a), 1'b1, 2'd0, "R5 inside");
        lookup(16'h090F, 1'b0, 2'd0, "R5 below");
        lookup(16'h0914, 1'b0, 2'd0, "R5 above");
    endtask

    task automatic t_disable();
        cfg_write(8'h84, 32'h910);
        lookup(16'h0910, 1'b0, 2'd0, "R4 disabled");
        lookup(16'h0913, 1'b0, 2'd0, "R4 disabled");
    endtask

    task automatic t_mask();
        cfg_write(8'h88, 32'h000C_0A01);
        lookup(16'h0A00, 1'b1, 2'd1, "R6 low");
        lookup(16'h0A0F, 1'b1, 2'd1, "R6 top");
        lookup(16'h0A10, 1'b0, 2'd0, "R6 past");
        cfg_write(8'h88, 32'h00FC_0A01);
        lookup(16'h0AFF, 1'b1, 2'd1, "R6 full");
        lookup(16'h0B00, 1'b0, 2'd0, "R6 full past");
        cfg_write(8'h88, 32'h0004_0A05);
        lookup(16'h0A04, 1'b0, 2'd0, "R6 base in ignored bit");
        lookup(16'h0A00, 1'b0, 2'd0, "R6 base in ignored bit");
    endtask

    task automatic t_priority();
        cfg_write(8'h84, 32'h0);
        cfg_write(8'h88, 32'h00FC_0A01);
        cfg_write(8'h8C, 32'h0000_0A41);
        cfg_write(8'h90, 32'h0000_0A41);
        lookup(16'h0A41, 1'b1, 2'd1, "R7 lowest");
        cfg_write(8'h88, 32'h00FC_0A00);
        lookup(16'h0A42, 1'b1, 2'd2, "R7 next");
        cfg_write(8'h8C, 32'h0);
        lookup(16'h0A43, 1'b1, 2'd3, "R7 last");
        lookup(16'h0A50, 1'b0, 2'd0, "R7 none");
    endtask

    task automatic t_timing();
        cfg_write(8'h84, 32'h911);
        @(negedge clk);
        io_addr = 16'h0910; io_valid = 1'b0;
        @(negedge clk);
        check("R8 no strobe", {31'b0, hit}, 32'h0);
        io_valid = 1'b1;
        @(negedge clk);
        check("R8 b2b first", {30'b0, hit, hit_idx[0]}, 32'h2);
        io_addr = 16'h0914;
        @(negedge clk);
        check("R8 b2b miss", {30'b0, hit, hit_idx[0]}, 32'h0);
        io_addr = 16'h0913;
        @(negedge clk);
        check("R8 b2b hit", {31'b0, hit}, 32'h1);
        io_valid = 1'b0;
        @(negedge clk);
        check("R8 drop", {30'b0, hit, hit_idx[0]}, 32'h0);
    endtask

    task automatic t_same_cycle();
        clear_all();
        cfg_write(8'h8C, 32'h0000_0A41);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 8'h8C; cfg_wdata = 32'h0;
        io_valid = 1'b1; io_addr = 16'h0A40;
        @(negedge clk);
        cfg_we = 1'b0; io_valid = 1'b0;
        check("R9 old contents hit", {31'b0, hit}, 32'h1);
        check("R9 old contents idx", {30'b0, hit_idx}, 32'h2);
        lookup(16'h0A40, 1'b0, 2'd0, "R9 after write");
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stray();
        t_regs();
        t_basic();
        t_disable();
        t_mask();
        t_priority();
        t_timing();
        t_same_cycle();
        finish_run();
    end
endmodule